// File: doc/BRIEF.md
# BCD Decimal Adjust Unit

This unit converts the binary result of an 8-bit add or subtract back into packed two-digit BCD. It takes the accumulator together with the carry, half-carry and subtract flags left by the previous arithmetic operation. From these it picks a correction offset of 00h, 06h, 60h or 66h.

The subtract flag sets the direction of the correction. When it is clear the offset is added; when it is set the offset is subtracted. The corrected byte and a fresh set of flags are registered on the clock edge that samples an input strobe. They appear together with an output strobe one cycle later and hold until the next strobe.

Top module: `bcd_adjust`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `res_valid` is 0 and every result output is 0.
- R2: `res_valid` equals the value `op_valid` had at the previous rising clock edge.
- R3: The 06h correction is selected when `hc_in` is 1 or the low nibble of the input accumulator (bits 3:0) is greater than 9. The test uses the input value before any correction.
- R4: The 60h correction is selected when `cy_in` is 1 or the whole input accumulator is 9Ah or greater. When both R3 and R4 hold, the offset is 66h.
- R5: `acc_out` is the input accumulator plus the selected offset when `sub_in` is 0, and minus the offset when `sub_in` is 1, modulo 256.
- R6: `cy_out` is 1 exactly when the 60h correction was selected under R4.
- R7: `hc_out` is the carry out of bit 3 when adding, or the borrow into bit 3 when subtracting, of the correction applied to the low nibble.
- R8: `z_out` is 1 when `acc_out` is 00h. `s_out` equals bit 7 of `acc_out`. `p_out` is 1 when `acc_out` has an even number of set bits.
- R9: `sub_out` equals the `sub_in` value sampled with the strobe.
- R10: In a cycle with `op_valid` low, all result outputs keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Input strobe |
| acc_in | input | 8 | Accumulator after the binary operation |
| cy_in | input | 1 | Carry flag from the previous operation |
| hc_in | input | 1 | Half-carry flag from the previous operation |
| sub_in | input | 1 | Subtract flag from the previous operation |
| res_valid | output | 1 | Output strobe |
| acc_out | output | 8 | Decimal-adjusted accumulator |
| cy_out | output | 1 | Carry flag after adjustment |
| hc_out | output | 1 | Half-carry flag after adjustment |
| z_out | output | 1 | Zero flag |
| s_out | output | 1 | Sign flag |
| p_out | output | 1 | Even-parity flag |
| sub_out | output | 1 | Subtract flag, passed through |

## Verification
The high-digit and low-digit corrections can both apply to the same byte. In that case the 66h offset and its half-carry or borrow are produced in one operation. The bench provokes this by sweeping every accumulator value under every combination of the three input flags, so many inputs meet both conditions at once. Examples are values of 9Ah and above with a low nibble above 9, and any value with both carry and half-carry set. A behavioural model computes the result and flags with plain integer arithmetic and checks them every clock. Idle gaps between strobes check that the outputs hold.

// File: rtl/bcd_adjust.sv
module bcd_adjust #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         op_valid,
  input  logic [W-1:0] acc_in,
  input  logic         cy_in,
  input  logic         hc_in,
  input  logic         sub_in,
  output logic         res_valid,
  output logic [W-1:0] acc_out,
  output logic         cy_out,
  output logic         hc_out,
  output logic         z_out,
  output logic         s_out,
  output logic         p_out,
  output logic         sub_out
);

  localparam logic [W-1:0] HI_LIMIT = W'(8'h9A);

  logic         fix_lo, fix_hi;
  logic [W-1:0] offset, sum;
  logic [4:0]   nib;

  assign fix_lo = hc_in || (acc_in[3:0] > 4'd9);
  assign fix_hi = cy_in || (acc_in >= HI_LIMIT);
  assign offset = {{(W-8){1'b0}}, fix_hi ? 4'h6 : 4'h0, fix_lo ? 4'h6 : 4'h0};
  assign sum    = sub_in ? acc_in - offset : acc_in + offset;
  assign nib    = sub_in ? {1'b0, acc_in[3:0]} - {1'b0, offset[3:0]}
                         : {1'b0, acc_in[3:0]} + {1'b0, offset[3:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      acc_out   <= '0;
      cy_out    <= 1'b0;
      hc_out    <= 1'b0;
      z_out     <= 1'b0;
      s_out     <= 1'b0;
      p_out     <= 1'b0;
      sub_out   <= 1'b0;
    end else begin
      res_valid <= op_valid;
      if (op_valid) begin
        acc_out <= sum;
        cy_out  <= fix_hi;
        hc_out  <= nib[4];
        z_out   <= (sum == '0);
        s_out   <= sum[W-1];
        p_out   <= ~^sum;
        sub_out <= sub_in;
      end
    end
  end

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid == $past(op_valid));

  // R6
  carry_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && (cy_in || acc_in >= HI_LIMIT)) |=> cy_out);

  // R9
  sub_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> sub_out == $past(sub_in));

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> ($stable(acc_out) && $stable(cy_out) && $stable(hc_out)));

  // R5
  no_fix_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !cy_in && !hc_in && acc_in < 8'h9A && acc_in[3:0] <= 4'd9)
      |=> acc_out == $past(acc_in));

  // R8
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (z_out == (acc_out == '0)));

endmodule

// File: tb/test_bcd_adjust.sv
module test_bcd_adjust;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic op_valid = 1'b0;
  logic [7:0] acc_in = 8'h00;
  logic cy_in = 1'b0, hc_in = 1'b0, sub_in = 1'b0;
  logic res_valid, cy_out, hc_out, z_out, s_out, p_out, sub_out;
  logic [7:0] acc_out;

  int vectors = 0;
  int fails = 0;
  int cycles = 0;
  bit checking = 1'b0;
  bit done = 1'b0;

  int m_valid = 0, m_acc = 0, m_cy = 0, m_hc = 0, m_z = 0, m_s = 0, m_p = 0, m_sub = 0;

  always #10 clk = ~clk;

  bcd_adjust i_bcd_adjust (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .acc_in(acc_in),
    .cy_in(cy_in), .hc_in(hc_in), .sub_in(sub_in),
    .res_valid(res_valid), .acc_out(acc_out), .cy_out(cy_out), .hc_out(hc_out),
    .z_out(z_out), .s_out(s_out), .p_out(p_out), .sub_out(sub_out)
  );

  always @(posedge clk) begin
    int a, off, r, ones;
    bit lo, hi;
    cycles++;
    if (!rst_n) begin
      m_valid = 0; m_acc = 0; m_cy = 0; m_hc = 0; m_z = 0; m_s = 0; m_p = 0; m_sub = 0;
    end else begin
      m_valid = op_valid;
      if (op_valid) begin
        a  = acc_in;
        lo = hc_in || (a % 16) > 9;
        hi = cy_in || a >= 154;
        off = (hi ? 96 : 0) + (lo ? 6 : 0);
        r = sub_in ? a - off : a + off;
        r = (r + 256) % 256;
        m_acc = r;
        m_cy  = hi;
        m_hc  = sub_in ? ((a % 16) < (off % 16)) : ((a % 16) + (off % 16) > 15);
        m_z   = (r == 0);
        m_s   = r / 128;
        ones = 0;
        for (int b = 0; b < 8; b++) ones += (r >> b) & 1;
        m_p   = (ones % 2 == 0);
        m_sub = sub_in;
      end
    end
  end

  task automatic cmp(input string tag, input int act, input int exp_v);
    if (act != exp_v) begin
      fails++;
      $display("FAIL %s acc_in=%02h cy=%0d hc=%0d sub=%0d: actual %0h expected %0h",
               tag, acc_in, cy_in, hc_in, sub_in, act, exp_v);
    end
  endtask

  always @(negedge clk) begin
    if (checking) begin
      vectors++;
      cmp("R2 res_valid", res_valid, m_valid);
      cmp("R3/R4/R5 acc_out", acc_out, m_acc);
      cmp("R6 cy_out", cy_out, m_cy);
      cmp("R7 hc_out", hc_out, m_hc);
      cmp("R8 z_out", z_out, m_z);
      cmp("R8 s_out", s_out, m_s);
      cmp("R8 p_out", p_out, m_p);
      cmp("R9 sub_out", sub_out, m_sub);
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    vectors++;
    cmp("R1 reset state", {res_valid, acc_out, cy_out, hc_out, z_out, s_out, p_out, sub_out}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    vectors++;
    cmp("R1 after reset", {res_valid, acc_out}, 0);
    checking = 1'b1;
    // R3 R4 R5 R7: sweep every value under every flag combination
    for (int f = 0; f < 8; f++) begin
      for (int v = 0; v < 256; v++) begin
        op_valid = 1'b1;
        acc_in = 8'(v);
        {sub_in, cy_in, hc_in} = 3'(f);
        @(negedge clk);
        if (v % 5 == 0) begin
          // R10: idle cycle with changed inputs, outputs must hold
          op_valid = 1'b0;
          acc_in = ~acc_in;
          {sub_in, cy_in, hc_in} = ~{sub_in, cy_in, hc_in};
          @(negedge clk);
        end
      end
    end
    op_valid = 1'b0;
    repeat (3) @(negedge clk);
    done = 1'b1;
  end

  initial begin
    wait (done || cycles > 20000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule